// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector

This block is the digital heart of an integer-N frequency synthesizer. It runs from one system clock. Two single-cycle strobes stand in for the edges of the two sources. `vco_tick` marks one period of the oscillator being tuned. `xtal_tick` marks one period of the crystal.

A 15-bit programmable divider counts oscillator periods. A reference divider counts crystal periods by 64, 80 or 128. A dual flip-flop phase/frequency detector compares the falling edges of the two divided signals. It produces UP and DOWN pulse requests and a high-impedance request for an external charge pump, all measured in system clock cycles.

A two-bit test code changes how the block behaves:

| Code | Behaviour |
|------|-----------|
| 00 | Normal operation. |
| 01 | Holds the pump in high impedance. |
| 10 | Shows both divided signals on the two port outputs. |
| 11 | The detector compares two external, synchronized inputs instead of the internal dividers. |

New divide ratios take effect only at a terminal count. A pump-current select bit is passed straight to the pump.

Top module: `intn_synth_core`

## Requirements
- R1: After reset, `pump_up` and `pump_dn` are 0 and `pump_hiz` is 1.
- R2: The divided oscillator signal (seen on `port_out[1]` under test code 10) has one falling edge every N `vco_tick` strobes, with N = `div_word`.
- R3: The divided reference signal (seen on `port_out[0]` under test code 10) falls once every R `xtal_tick` strobes. R is 80 when `ref_sel_b`=0, whatever the value of `ref_sel_a`. R is 128 when `ref_sel_a`=0 and `ref_sel_b`=1. R is 64 when both are 1.
- R4: A `div_word` below 256 divides by 256.
- R5: When the divided oscillator falls before the divided reference, `pump_up` is high for exactly as many clock cycles as separate the two falling edges.
- R6: In the opposite order, `pump_dn` is high for exactly that many cycles.
- R7: Falling edges arriving in the same cycle raise neither output, and `pump_hiz` stays 1.
- R8: `pump_up` and `pump_dn` are never 1 together.
- R9: `test_mode`=01 holds `pump_up`=`pump_dn`=0 and `pump_hiz`=1, even while the dividers keep producing phase error.
- R10: `test_mode`=10 drives the divided reference onto `port_out[0]` and the divided oscillator onto `port_out[1]`. Any other code passes `port_val[0]` and `port_val[1]` through.
- R11: `test_mode`=11 feeds the detector from `ext_in[1]` (oscillator side) and `ext_in[0]` (reference side). In this mode the internal dividers have no effect on the pump outputs.
- R12: `pump_cur_high` follows `cur_high_sel` (1 selects the high pump current).
- R13: A ratio written in the middle of a divider period is first used after the current period has ended. The period in progress finishes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vco_tick | input | 1 | One strobe per oscillator period |
| xtal_tick | input | 1 | One strobe per crystal period |
| div_word | input | 15 | Programmable divide ratio N |
| ref_sel_a | input | 1 | Reference ratio select, first bit |
| ref_sel_b | input | 1 | Reference ratio select, second bit |
| test_mode | input | 2 | Test code, bit 1 first (00 normal, 01 pump off, 10 probe, 11 external) |
| cur_high_sel | input | 1 | Pump current select |
| port_val | input | 2 | Software values for the two ports |
| ext_in | input | 2 | External compare inputs: bit 1 oscillator side, bit 0 reference side |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_hiz | output | 1 | Pump output high-impedance request |
| pump_cur_high | output | 1 | High pump current selected |
| port_out | output | 2 | Port pins (probe outputs under code 10) |

## Verification
A counter that wraps at the wrong count shows up on a probe port as a falling-edge spacing that is off by one or more strobes. This becomes visible one full divider period after the fault, which is up to N strobes later. A detector flop that fails to set or clear shows up as a pulse on `pump_up` or `pump_dn` one cycle too long or short. It can also show as a pulse that never ends, in which case the stuck output stays high until the next edge on the other side. A ratio loaded too early changes the width of the period in progress, so the very next edge spacing is wrong.

// File: rtl/intn_synth_core_pkg.sv
package intn_synth_core_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL   = 2'b00,
    TM_PUMP_OFF = 2'b01,
    TM_PROBE    = 2'b10,
    TM_EXTERNAL = 2'b11
  } test_mode_e;

  // Reference ratio from the two select bits; sel_a matters only when sel_b is set.
  function automatic int unsigned ref_ratio(input logic sel_a, input logic sel_b,
                                            input int unsigned r_b0,
                                            input int unsigned r_b1_a0,
                                            input int unsigned r_b1_a1);
    if (!sel_b)
      return r_b0;
    else if (!sel_a)
      return r_b1_a0;
    else
      return r_b1_a1;
  endfunction

  // Programmable ratio with a lower bound.
  function automatic int unsigned prog_ratio(input int unsigned word, input int unsigned n_min);
    return (word < n_min) ? n_min : word;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] ratio_in,
  output logic         div_q,
  output logic         tc,
  output logic [W-1:0] ratio_act
);

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] ratio_nxt;

  // Terminal count: the last strobe of the period in progress.
  assign tc = tick && (cnt == ratio_act - W'(1));

  always_comb begin
    cnt_nxt   = tc ? '0 : cnt + W'(1);
    ratio_nxt = tc ? ratio_in : ratio_act;
  end

  // Output is low for the first half of a period and high for the second,
  // so it falls exactly at the wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      ratio_act <= ratio_in;
      div_q     <= 1'b0;
    end else if (tick) begin
      cnt       <= cnt_nxt;
      ratio_act <= ratio_nxt;
      div_q     <= (cnt_nxt >= (ratio_nxt >> 1));
    end
  end

endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sr <= '1;
    else
      sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/phase_det.sv
module phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic vco_lvl,
  input  logic ref_lvl,
  output logic up_q,
  output logic dn_q,
  output logic vco_fall,
  output logic ref_fall
);

  logic vco_prev;
  logic ref_prev;
  logic up_set;
  logic dn_set;

  assign vco_fall = vco_prev & ~vco_lvl;
  assign ref_fall = ref_prev & ~ref_lvl;

  always_comb begin
    up_set = up_q | vco_fall;
    dn_set = dn_q | ref_fall;
  end

  // Once both edges have arrived, both flops clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vco_prev <= 1'b0;
      ref_prev <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
    end else begin
      vco_prev <= vco_lvl;
      ref_prev <= ref_lvl;
      if (up_set && dn_set) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= up_set;
        dn_q <= dn_set;
      end
    end
  end

endmodule

// File: rtl/intn_synth_core.sv
module intn_synth_core
  import intn_synth_core_pkg::*;
#(
  parameter int N_W          = 15,
  parameter int REF_W        = 8,
  parameter int N_MIN        = 256,
  parameter int REF_B0       = 80,
  parameter int REF_B1_A0    = 128,
  parameter int REF_B1_A1    = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_tick,
  input  logic           xtal_tick,
  input  logic [N_W-1:0] div_word,
  input  logic           ref_sel_a,
  input  logic           ref_sel_b,
  input  logic [1:0]     test_mode,
  input  logic           cur_high_sel,
  input  logic [1:0]     port_val,
  input  logic [1:0]     ext_in,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           pump_hiz,
  output logic           pump_cur_high,
  output logic [1:0]     port_out
);

  localparam int EXT_N = 2;

  test_mode_e mode;
  assign mode = test_mode_e'(test_mode);

  // Ratio words for the two dividers.
  logic [N_W-1:0]   prog_ratio_in;
  logic [REF_W-1:0] ref_ratio_in;
  assign prog_ratio_in = N_W'(prog_ratio(32'(div_word), N_MIN));
  assign ref_ratio_in  = REF_W'(ref_ratio(ref_sel_a, ref_sel_b, REF_B0, REF_B1_A0, REF_B1_A1));

  // Named internal events, brought out for the checker.
  logic             vco_div_lvl;
  logic             ref_div_lvl;
  logic             prog_tc;
  logic             ref_tc;
  logic [N_W-1:0]   prog_ratio_act;
  logic [REF_W-1:0] ref_ratio_act;
  logic [EXT_N-1:0] ext_lvl;
  logic             det_vco_lvl;
  logic             det_ref_lvl;
  logic             det_vco_fall;
  logic             det_ref_fall;
  logic             up_raw;
  logic             dn_raw;
  logic             pump_off;
  logic             probe_on;

  tick_divider #(.W(N_W)) u_prog_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (vco_tick),
    .ratio_in  (prog_ratio_in),
    .div_q     (vco_div_lvl),
    .tc        (prog_tc),
    .ratio_act (prog_ratio_act)
  );

  tick_divider #(.W(REF_W)) u_ref_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (xtal_tick),
    .ratio_in  (ref_ratio_in),
    .div_q     (ref_div_lvl),
    .tc        (ref_tc),
    .ratio_act (ref_ratio_act)
  );

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext_sync
    level_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_in[g]),
      .q     (ext_lvl[g])
    );
  end

  always_comb begin
    if (mode == TM_EXTERNAL) begin
      det_vco_lvl = ext_lvl[1];
      det_ref_lvl = ext_lvl[0];
    end else begin
      det_vco_lvl = vco_div_lvl;
      det_ref_lvl = ref_div_lvl;
    end
  end

  phase_det u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .vco_lvl  (det_vco_lvl),
    .ref_lvl  (det_ref_lvl),
    .up_q     (up_raw),
    .dn_q     (dn_raw),
    .vco_fall (det_vco_fall),
    .ref_fall (det_ref_fall)
  );

  assign pump_off = (mode == TM_PUMP_OFF);
  assign probe_on = (mode == TM_PROBE);

  assign pump_up       = up_raw & ~pump_off;
  assign pump_dn       = dn_raw & ~pump_off;
  assign pump_hiz      = ~(pump_up | pump_dn);
  assign pump_cur_high = cur_high_sel;

  assign port_out[0] = probe_on ? ref_div_lvl : port_val[0];
  assign port_out[1] = probe_on ? vco_div_lvl : port_val[1];

endmodule

// File: rtl/intn_synth_core_chk.sv
module intn_synth_core_chk #(
  parameter int N_W   = 15,
  parameter int REF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       test_mode,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             pump_hiz,
  input logic             up_raw,
  input logic             dn_raw,
  input logic             det_vco_fall,
  input logic             det_ref_fall,
  input logic             prog_tc,
  input logic             ref_tc,
  input logic [N_W-1:0]   prog_ratio_act,
  input logic [REF_W-1:0] ref_ratio_act
);

  p_up_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_raw) |-> $past(det_vco_fall));

  p_up_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_raw && det_ref_fall) |=> !up_raw);

  p_dn_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_raw) |-> $past(det_ref_fall));

  p_dn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_raw && det_vco_fall) |=> !dn_raw);

  p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_raw && !dn_raw && det_vco_fall && det_ref_fall) |=> (!up_raw && !dn_raw));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  p_pump_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b01) |-> (pump_hiz && !pump_up && !pump_dn));

  p_prog_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_ratio_act) |-> $past(prog_tc));

  p_ref_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_ratio_act) |-> $past(ref_tc));

endmodule

bind intn_synth_core intn_synth_core_chk #(.N_W(N_W), .REF_W(REF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .test_mode      (test_mode),
  .pump_up        (pump_up),
  .pump_dn        (pump_dn),
  .pump_hiz       (pump_hiz),
  .up_raw         (up_raw),
  .dn_raw         (dn_raw),
  .det_vco_fall   (det_vco_fall),
  .det_ref_fall   (det_ref_fall),
  .prog_tc        (prog_tc),
  .ref_tc         (ref_tc),
  .prog_ratio_act (prog_ratio_act),
  .ref_ratio_act  (ref_ratio_act)
);

// File: tb/intn_synth_core_tb_top.sv
module intn_synth_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_tick = 1'b0;
  logic        xtal_tick = 1'b0;
  logic [14:0] div_word = 15'd256;
  logic        ref_sel_a = 1'b0;
  logic        ref_sel_b = 1'b0;
  logic [1:0]  test_mode = 2'b00;
  logic        cur_high_sel = 1'b0;
  logic [1:0]  port_val = 2'b00;
  logic [1:0]  ext_in = 2'b11;
  logic        pump_up, pump_dn, pump_hiz, pump_cur_high;
  logic [1:0]  port_out;

  intn_synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .div_word(div_word), .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b),
    .test_mode(test_mode), .cur_high_sel(cur_high_sel), .port_val(port_val),
    .ext_in(ext_in), .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .pump_cur_high(pump_cur_high), .port_out(port_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int tick_cnt = 0;
  bit tick_on = 1'b0;

  // Monitor state
  int  v_falls = 0, v_last = 0;
  int  r_falls = 0, r_last = 0;
  logic p0_prev = 1'b0, p1_prev = 1'b0;
  bit  count_en = 1'b0;
  int  c_up = 0, c_dn = 0, c_both = 0, c_nothiz = 0;

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // Both sources strobe every second clock.
  initial forever begin
    @(posedge clk);
    #1;
    tick_on   = ~tick_on;
    vco_tick  = tick_on;
    xtal_tick = tick_on;
    if (tick_on) tick_cnt++;
  end

  always @(negedge clk) begin
    if (test_mode == 2'b10) begin
      if (p1_prev && !port_out[1]) begin v_last = tick_cnt; v_falls++; end
      if (p0_prev && !port_out[0]) begin r_last = tick_cnt; r_falls++; end
    end
    p0_prev = port_out[0];
    p1_prev = port_out[1];
    if (count_en) begin
      if (pump_up) c_up++;
      if (pump_dn) c_dn++;
      if (pump_up && pump_dn) c_both++;
      if (!pump_hiz) c_nothiz++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ref(input bit a, input bit b);
    if (b == 1'b0) return 80;
    return a ? 64 : 128;
  endfunction

  function automatic int exp_prog(input int w);
    return (w < 256) ? 256 : w;
  endfunction

  task automatic wait_vfall();
    int s = v_falls;
    while (v_falls == s) @(negedge clk);
  endtask

  task automatic wait_rfall();
    int s = r_falls;
    while (r_falls == s) @(negedge clk);
  endtask

  task automatic vco_period(output int per);
    int t0;
    wait_vfall();
    t0 = v_last;
    wait_vfall();
    per = v_last - t0;
  endtask

  task automatic ref_period(output int per);
    int t0;
    wait_rfall();
    t0 = r_last;
    wait_rfall();
    per = r_last - t0;
  endtask

  task automatic clear_counts();
    c_up = 0; c_dn = 0; c_both = 0; c_nothiz = 0;
  endtask

  task automatic at_drive();
    @(posedge clk);
    #2;
  endtask

  // External edges: first falls, d cycles later the other falls.
  task automatic ext_pair(input bit vco_first, input int d);
    clear_counts();
    count_en = 1'b1;
    at_drive();
    if (d == 0) ext_in = 2'b00;
    else ext_in = vco_first ? 2'b01 : 2'b10;
    repeat (d) at_drive();
    ext_in = 2'b00;
    repeat (8) at_drive();
    ext_in = 2'b11;
    repeat (8) at_drive();
    count_en = 1'b0;
  endtask

  initial begin
    int per;
    int w;
    int d;
    bit vf;
    void'($urandom(32'd20240611));

    repeat (5) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(pump_up == 1'b0, "R1 up", pump_up, 0);
    check(pump_dn == 1'b0, "R1 dn", pump_dn, 0);
    check(pump_hiz == 1'b1, "R1 hiz", pump_hiz, 1);

    // R12 current select
    at_drive(); cur_high_sel = 1'b1; @(negedge clk);
    check(pump_cur_high == 1'b1, "R12 high", pump_cur_high, 1);
    at_drive(); cur_high_sel = 1'b0; @(negedge clk);
    check(pump_cur_high == 1'b0, "R12 low", pump_cur_high, 0);

    // R10 passthrough in normal mode
    at_drive(); port_val = 2'b01; @(negedge clk);
    check(port_out == 2'b01, "R10 pass 01", port_out, 1);
    at_drive(); port_val = 2'b10; @(negedge clk);
    check(port_out == 2'b10, "R10 pass 10", port_out, 2);
    at_drive(); port_val = 2'b00; test_mode = 2'b10;

    // R3 reference ratio codes (R10 probe shows them)
    for (int k = 0; k < 4; k++) begin
      at_drive();
      ref_sel_a = k[0];
      ref_sel_b = k[1];
      ref_period(per);
      check(per == exp_ref(k[0], k[1]), "R3 ref ratio", per, exp_ref(k[0], k[1]));
    end

    // R2 directed and random ratios
    at_drive(); div_word = 15'd256;
    vco_period(per);
    check(per == 256, "R2 N=256", per, 256);
    for (int k = 0; k < 4; k++) begin
      w = $urandom_range(900, 257);
      at_drive(); div_word = 15'(w);
      vco_period(per);
      check(per == exp_prog(w), "R2 random N", per, exp_prog(w));
    end

    // R4 lower bound
    at_drive(); div_word = 15'd5;
    vco_period(per);
    check(per == exp_prog(5), "R4 clamp", per, 256);

    // R13 ratio change mid-period
    at_drive(); div_word = 15'd300;
    vco_period(per);
    check(per == 300, "R13 setup", per, 300);
    repeat (50) at_drive();
    div_word = 15'd400;
    w = v_last;
    wait_vfall();
    check(v_last - w == 300, "R13 old ratio kept", v_last - w, 300);
    w = v_last;
    wait_vfall();
    check(v_last - w == 400, "R13 new ratio", v_last - w, 400);

    // Internal phase error, normal mode: R6 down pulses expected
    at_drive();
    div_word = 15'd256; ref_sel_a = 1'b1; ref_sel_b = 1'b1; test_mode = 2'b00;
    clear_counts(); count_en = 1'b1;
    repeat (3000) at_drive();
    count_en = 1'b0;
    check(c_dn > 0, "R6 internal down seen", c_dn, 1);
    check(c_both == 0, "R8 internal", c_both, 0);

    // R9 pump off
    test_mode = 2'b01;
    @(negedge clk);
    clear_counts(); count_en = 1'b1;
    repeat (3000) at_drive();
    count_en = 1'b0;
    check(c_up == 0 && c_dn == 0, "R9 no pulses", c_up + c_dn, 0);
    check(c_nothiz == 0, "R9 hiz held", c_nothiz, 0);

    // External mode
    test_mode = 2'b11;
    ext_in = 2'b11;
    repeat (10) at_drive();
    ext_pair(1'b0, 0);
    ext_pair(1'b0, 0);
    check(c_up == 0 && c_dn == 0, "R7 coincident", c_up + c_dn, 0);
    check(c_nothiz == 0, "R7 hiz", c_nothiz, 0);

    // R11 internal dividers ignored
    clear_counts(); count_en = 1'b1;
    repeat (1500) at_drive();
    count_en = 1'b0;
    check(c_up == 0 && c_dn == 0, "R11 internal ignored", c_up + c_dn, 0);

    ext_pair(1'b1, 1);
    check(c_up == 1 && c_dn == 0, "R5 width 1", c_up, 1);
    ext_pair(1'b0, 1);
    check(c_dn == 1 && c_up == 0, "R6 width 1", c_dn, 1);
    for (int k = 0; k < 8; k++) begin
      d  = $urandom_range(30, 1);
      vf = 1'($urandom_range(1, 0));
      ext_pair(vf, d);
      if (vf) check(c_up == d && c_dn == 0, "R5 random width", c_up, d);
      else    check(c_dn == d && c_up == 0, "R6 random width", c_dn, d);
      check(c_both == 0, "R8 external", c_both, 0);
      check(c_nothiz == d, "R7 hiz outside pulse", c_nothiz, d);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule